// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects interrupt requests from a set of external sources and distributes them to several processors. Each source is configured through one word that sets its vector, priority, input sense (level or edge), input polarity and a mask bit, and through a destination word with one bit per processor. Each processor has a task-priority register, an acknowledge register and an end-of-interrupt register. A source reaches a processor only if it is pending, unmasked, and routed to that processor. It must also not be in service anywhere, and its priority must be strictly above both the processor's task priority and the highest priority that processor already has in service.

Software reads the acknowledge register to learn which vector to service. That read moves the source into the processor's in-service set. A write to the end-of-interrupt register retires the highest in-service level, which allows interrupts to nest by priority. When nothing is eligible, the acknowledge read returns a programmable spurious vector. A self-clearing reset bit returns all registers to their defaults. A read-only feature word reports the source count, the processor count and a version code.

Register access uses a single-port word bus. Reads return data one cycle after the request. Word addresses: 0x00 global config, 0x01 feature, 0x02 spurious vector, 0x10+2s source s vector/priority, 0x11+2s source s destination, 0x40+4c processor c task priority, 0x41+4c acknowledge, 0x42+4c end-of-interrupt.

Top module: `mpint_ctrl`

## Requirements
- R1: After reset, every source word reads 0x8000_0000 (masked), every destination reads 0, every task priority reads 15, the spurious vector reads 0xFF, no irq_out is high, and the feature word reads {last source index in bits 23:16, last processor index in bits 11:8, version in bits 3:0} (0x0007_0102 by default).
- R2: The source word reads back what was last written: vector in bits 7:0, priority in bits 19:16, level sense in bit 22, active-high polarity in bit 23, mask in bit 31.
- R3: A source is delivered only to processors whose bit (bit c for processor c) is set in its destination word.
- R4: A processor receives a source only if the source priority is strictly greater than its task priority; a task priority of 15 blocks all delivery.
- R5: An acknowledge read returns the vector of the highest-priority eligible source, with ties going to the lowest source number, and places that source in service.
- R6: An acknowledge read with nothing eligible returns the programmed spurious vector (bits 7:0 of word 0x02) and changes no state.
- R7: A source is delivered only if its priority is strictly above the processor's highest in-service priority. Any write to the end-of-interrupt register retires the highest-priority in-service source of that processor.
- R8: An edge source latches an active edge. The acknowledge clears the latch. An edge that arrives while the source is in service stays latched and is delivered again after the end-of-interrupt.
- R9: A level source is pending while its input is active. It is offered again after its end-of-interrupt if the input is still active.
- R10: A masked source is never delivered.
- R11: Writing 1 to global config bit 0 resets the controller. The bit reads 1 for a fixed number of cycles (4 by default), then reads 0, and all registers hold their reset values.
- R12: Global config bit 1 is a stored bit that reads back as written and is cleared by reset.
- R13: With the polarity bit clear, a source is active when its input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| src_in | input | N_SRC | Interrupt source inputs |
| irq_out | output | N_CPU | Per-processor interrupt request |

## Verification
The tests drive single-cycle edge pulses, held level inputs, an active-low level input, and two equal-priority sources raised together. Comparing these patterns separates edge latching from level tracking, and shows that ties go to the lowest source number. A lower-priority service followed by a higher-priority arrival exercises nesting. Each end-of-interrupt is then checked to retire the right level and to re-offer a level input that is still asserted. Task-priority values equal to, below and at the maximum relative to the source priority confirm the strict comparison. A soft reset in mid-run is checked to clear everything the earlier tests programmed.

// File: rtl/mpint_pkg.sv
package mpint_pkg;
    localparam int DW    = 32;
    localparam int PRI_W = 4;
    localparam int VEC_W = 8;

    // source word field positions
    localparam int VP_PRI_LSB = 16;
    localparam int VP_LEVEL   = 22;
    localparam int VP_POL     = 23;
    localparam int VP_MASK    = 31;

    // global config bits
    localparam int GC_RESET = 0;
    localparam int GC_PTHRU = 1;

    // word address map
    localparam int A_GCONF    = 8'h00;
    localparam int A_FEAT     = 8'h01;
    localparam int A_SPUR     = 8'h02;
    localparam int A_SRC_BASE = 8'h10;
    localparam int A_CPU_BASE = 8'h40;

    typedef struct packed {
        logic             mask;
        logic             pol;
        logic             level;
        logic [PRI_W-1:0] pri;
        logic [VEC_W-1:0] vec;
    } vecpri_t;

    function automatic logic [DW-1:0] vp_pack(vecpri_t v);
        logic [DW-1:0] w;
        w = '0;
        w[VP_MASK]                 = v.mask;
        w[VP_POL]                  = v.pol;
        w[VP_LEVEL]                = v.level;
        w[VP_PRI_LSB +: PRI_W]     = v.pri;
        w[VEC_W-1:0]               = v.vec;
        return w;
    endfunction

    function automatic vecpri_t vp_unpack(logic [DW-1:0] w);
        vecpri_t v;
        v.mask  = w[VP_MASK];
        v.pol   = w[VP_POL];
        v.level = w[VP_LEVEL];
        v.pri   = w[VP_PRI_LSB +: PRI_W];
        v.vec   = w[VEC_W-1:0];
        return v;
    endfunction
endpackage

// File: rtl/mpint_src.sv
module mpint_src (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic raw,
    input  logic level,
    input  logic pol_pos,
    input  logic clr,
    output logic pending
);
    typedef struct packed {
        logic samp;
        logic prev;
        logic edge_lat;
    } st_t;

    st_t st_d, st_q;
    logic act_now, act_prev;

    always_comb begin
        act_now  = pol_pos ? st_q.samp : ~st_q.samp;
        act_prev = pol_pos ? st_q.prev : ~st_q.prev;
        st_d      = st_q;
        st_d.samp = raw;
        st_d.prev = st_q.samp;
        if (clr)
            st_d.edge_lat = 1'b0;
        // a new edge wins over a same-cycle clear
        if (!level && act_now && !act_prev)
            st_d.edge_lat = 1'b1;
        if (soft_rst)
            st_d.edge_lat = 1'b0;
        pending = level ? act_now : st_q.edge_lat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_edge_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.edge_lat && !clr && !soft_rst) |=> st_q.edge_lat);
endmodule

// File: rtl/mpint_cpu.sv
module mpint_cpu
    import mpint_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        soft_rst,
    input  logic [N_SRC-1:0]            pend,
    input  logic [N_SRC-1:0]            mask,
    input  logic [N_SRC-1:0]            dest,
    input  logic [N_SRC-1:0]            busy,
    input  logic [N_SRC-1:0][PRI_W-1:0] pri,
    input  logic [PRI_W-1:0]            tpri,
    input  logic                        ack,
    input  logic                        eoi,
    output logic                        irq,
    output logic [IDX_W-1:0]            sel,
    output logic [N_SRC-1:0]            isr
);
    typedef struct packed {
        logic [N_SRC-1:0] isr;
    } st_t;

    st_t st_d, st_q;
    logic             best_ok, top_ok;
    logic [IDX_W-1:0] best_idx, top_idx;
    logic [PRI_W-1:0] best_pri, cur_pri;

    always_comb begin
        // current in-service level and the source holding it
        top_ok  = 1'b0;
        top_idx = '0;
        cur_pri = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (st_q.isr[s] && (!top_ok || pri[s] > cur_pri)) begin
                top_ok  = 1'b1;
                top_idx = IDX_W'(s);
                cur_pri = pri[s];
            end
        end
        // highest eligible source, lowest index on ties
        best_ok  = 1'b0;
        best_idx = '0;
        best_pri = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (pend[s] && !mask[s] && dest[s] && !busy[s] &&
                pri[s] > tpri && pri[s] > cur_pri &&
                (!best_ok || pri[s] > best_pri)) begin
                best_ok  = 1'b1;
                best_idx = IDX_W'(s);
                best_pri = pri[s];
            end
        end
        st_d = st_q;
        if (ack && best_ok)
            st_d.isr[best_idx] = 1'b1;
        if (eoi && top_ok)
            st_d.isr[top_idx] = 1'b0;
        if (soft_rst)
            st_d.isr = '0;
        irq = best_ok;
        sel = best_idx;
        isr = st_q.isr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_ack_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !soft_rst) |=> st_q.isr[$past(sel)]);

    assert_eoi_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && !soft_rst && (st_q.isr != '0)) |=>
        ($countones(st_q.isr) == $countones($past(st_q.isr)) - 1));
endmodule

// File: rtl/mpint_ctrl.sv
module mpint_ctrl
    import mpint_pkg::*;
#(
    parameter int          N_SRC    = 8,
    parameter int          N_CPU    = 2,
    parameter int          VERSION  = 2,
    parameter int          RST_CYC  = 4,
    parameter logic [7:0]  SPUR_RST = 8'hFF,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CNT_W = $clog2(RST_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [N_SRC-1:0] src_in,
    output logic [N_CPU-1:0] irq_out
);
    localparam logic [DW-1:0] FEAT_WORD =
        {8'h00, 8'(N_SRC - 1), 4'h0, 4'(N_CPU - 1), 4'h0, 4'(VERSION)};

    typedef struct packed {
        vecpri_t [N_SRC-1:0]               vp;
        logic    [N_SRC-1:0][N_CPU-1:0]    dest;
        logic    [N_CPU-1:0][PRI_W-1:0]    tpri;
        logic    [VEC_W-1:0]               spur;
        logic                              pthru;
        logic    [CNT_W-1:0]               rcnt;
        logic    [DW-1:0]                  rdata;
    } st_t;

    function automatic st_t rst_state();
        st_t r;
        r = '0;
        for (int s = 0; s < N_SRC; s++) r.vp[s].mask = 1'b1;
        for (int c = 0; c < N_CPU; c++) r.tpri[c] = '1;
        r.spur = SPUR_RST;
        return r;
    endfunction

    st_t st_d, st_q;
    logic                              soft_rst;
    logic [DW-1:0]                     rd_word;
    logic [N_CPU-1:0]                  ack_v, eoi_v, irq_v;
    logic [N_CPU-1:0][IDX_W-1:0]       sel;
    logic [N_CPU-1:0][N_SRC-1:0]       isr_a, dest_col;
    logic [N_SRC-1:0]                  pend_v, mask_v, level_v, pol_v, busy_v, clr_v;
    logic [N_SRC-1:0][PRI_W-1:0]       pri_a;
    logic                              unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign soft_rst     = (st_q.rcnt != '0);
    assign bus_rdata    = st_q.rdata;
    assign irq_out      = irq_v;

    // unpack configuration for the sub-blocks
    always_comb begin
        for (int s = 0; s < N_SRC; s++) begin
            mask_v[s]  = st_q.vp[s].mask;
            level_v[s] = st_q.vp[s].level;
            pol_v[s]   = st_q.vp[s].pol;
            pri_a[s]   = st_q.vp[s].pri;
            for (int c = 0; c < N_CPU; c++)
                dest_col[c][s] = st_q.dest[s][c];
        end
        busy_v = '0;
        for (int c = 0; c < N_CPU; c++)
            busy_v = busy_v | isr_a[c];
        clr_v = '0;
        for (int c = 0; c < N_CPU; c++)
            for (int s = 0; s < N_SRC; s++)
                if (ack_v[c] && sel[c] == IDX_W'(s))
                    clr_v[s] = 1'b1;
    end

    // register file, bus decode and soft reset
    always_comb begin
        st_d    = st_q;
        rd_word = st_q.rdata;
        ack_v   = '0;
        eoi_v   = '0;
        if (bus_rd) begin
            rd_word = '0;
            if (bus_addr == 8'(A_GCONF)) begin
                rd_word[GC_RESET] = soft_rst;
                rd_word[GC_PTHRU] = st_q.pthru;
            end
            if (bus_addr == 8'(A_FEAT)) rd_word = FEAT_WORD;
            if (bus_addr == 8'(A_SPUR)) rd_word = DW'(st_q.spur);
            for (int s = 0; s < N_SRC; s++) begin
                if (bus_addr == 8'(A_SRC_BASE + 2 * s))     rd_word = vp_pack(st_q.vp[s]);
                if (bus_addr == 8'(A_SRC_BASE + 2 * s + 1)) rd_word = DW'(st_q.dest[s]);
            end
            for (int c = 0; c < N_CPU; c++) begin
                if (bus_addr == 8'(A_CPU_BASE + 4 * c)) rd_word = DW'(st_q.tpri[c]);
                if (bus_addr == 8'(A_CPU_BASE + 4 * c + 1)) begin
                    rd_word = DW'(st_q.spur);
                    if (!soft_rst && irq_v[c]) begin
                        rd_word  = DW'(st_q.vp[sel[c]].vec);
                        ack_v[c] = 1'b1;
                    end
                end
            end
        end
        st_d.rdata = rd_word;
        if (bus_wr && !soft_rst) begin
            if (bus_addr == 8'(A_GCONF)) begin
                st_d.pthru = bus_wdata[GC_PTHRU];
                if (bus_wdata[GC_RESET]) st_d.rcnt = CNT_W'(RST_CYC);
            end
            if (bus_addr == 8'(A_SPUR)) st_d.spur = bus_wdata[VEC_W-1:0];
            for (int s = 0; s < N_SRC; s++) begin
                if (bus_addr == 8'(A_SRC_BASE + 2 * s))     st_d.vp[s]   = vp_unpack(bus_wdata);
                if (bus_addr == 8'(A_SRC_BASE + 2 * s + 1)) st_d.dest[s] = bus_wdata[N_CPU-1:0];
            end
            for (int c = 0; c < N_CPU; c++) begin
                if (bus_addr == 8'(A_CPU_BASE + 4 * c))     st_d.tpri[c] = bus_wdata[PRI_W-1:0];
                if (bus_addr == 8'(A_CPU_BASE + 4 * c + 2)) eoi_v[c]     = 1'b1;
            end
        end
        if (soft_rst) begin
            st_d       = rst_state();
            st_d.rcnt  = st_q.rcnt - 1'b1;
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rst_state();
        else        st_q <= st_d;
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        mpint_src u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .raw      (src_in[s]),
            .level    (level_v[s]),
            .pol_pos  (pol_v[s]),
            .clr      (clr_v[s]),
            .pending  (pend_v[s])
        );
    end

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        mpint_cpu #(.N_SRC(N_SRC)) u_cpu (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .pend     (pend_v),
            .mask     (mask_v),
            .dest     (dest_col[c]),
            .busy     (busy_v),
            .pri      (pri_a),
            .tpri     (st_q.tpri[c]),
            .ack      (ack_v[c]),
            .eoi      (eoi_v[c]),
            .irq      (irq_v[c]),
            .sel      (sel[c]),
            .isr      (isr_a[c])
        );

        assert_task_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.tpri[c] == '1) |-> !irq_out[c]);

        assert_irq_backed_R10: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[c] |-> (|(~mask_v & dest_col[c] & pend_v & ~busy_v)));
    end

    assert_rst_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (irq_out == '0));
endmodule

// File: tb/mpint_ctrl_bench.sv
`timescale 1ns/1ps
module mpint_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  src_in = 8'h40;   // source 6 idles high (active-low use)
    logic [1:0]  irq_out;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    mpint_ctrl u_mpint_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_out(irq_out)
    );

    localparam logic [7:0] GCONF = 8'h00, FEAT = 8'h01, SPUR = 8'h02;
    function automatic logic [7:0] a_vp(int s);   return 8'(16 + 2 * s);     endfunction
    function automatic logic [7:0] a_dst(int s);  return 8'(17 + 2 * s);     endfunction
    function automatic logic [7:0] a_tp(int c);   return 8'(64 + 4 * c);     endfunction
    function automatic logic [7:0] a_ack(int c);  return 8'(65 + 4 * c);     endfunction
    function automatic logic [7:0] a_eoi(int c);  return 8'(66 + 4 * c);     endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic irq_chk(input logic [1:0] exp, input string tag);
        checks++;
        if (irq_out !== exp) begin
            fails++;
            $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_src(input int i, input logic v);
        @(negedge clk); src_in[i] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        irq_chk(2'b00, "R1 idle");
        rd_chk(FEAT, 32'h0007_0102, "R1 feature");
        rd_chk(GCONF, 32'h0, "R1 gconf");
        rd_chk(SPUR, 32'hFF, "R1 spurious");
        rd_chk(a_vp(0), 32'h8000_0000, "R1 vecpri");
        rd_chk(a_dst(0), 32'h0, "R1 dest");
        rd_chk(a_tp(1), 32'hF, "R1 task");
        rd_chk(a_ack(0), 32'hFF, "R1 ack");

        // configuration
        wr(a_vp(0), 32'h0085_0020); wr(a_dst(0), 32'h1);   // edge, pri5
        wr(a_vp(1), 32'h00C9_0021); wr(a_dst(1), 32'h3);   // level, pri9
        wr(a_vp(2), 32'h00C5_0022); wr(a_dst(2), 32'h1);   // level, pri5
        wr(a_vp(4), 32'h00C5_0024); wr(a_dst(4), 32'h2);
        wr(a_vp(5), 32'h00C5_0025); wr(a_dst(5), 32'h2);
        wr(a_tp(0), 32'h0); wr(a_tp(1), 32'h0);
        rd_chk(a_vp(1), 32'h00C9_0021, "R2 readback");
        irq_chk(2'b00, "R9 inputs idle");

        // edge source, destination, task priority
        set_src(0, 1'b1); set_src(0, 1'b0); idle(3);
        irq_chk(2'b01, "R3 dest cpu0 only");
        rd_chk(a_ack(1), 32'hFF, "R3 cpu1 not routed");
        wr(a_tp(0), 32'h5); irq_chk(2'b00, "R4 equal priority blocked");
        wr(a_tp(0), 32'h4); irq_chk(2'b01, "R4 lower task passes");
        wr(a_tp(0), 32'hF); irq_chk(2'b00, "R4 task 15 blocks");
        wr(a_tp(0), 32'h0);
        rd_chk(a_ack(0), 32'h20, "R5 ack edge vector");
        irq_chk(2'b00, "R8 latch cleared");
        set_src(0, 1'b1); set_src(0, 1'b0); idle(3);
        irq_chk(2'b00, "R8 in service holds");
        wr(a_eoi(0), 32'h0);
        irq_chk(2'b01, "R8 redelivered after eoi");
        rd_chk(a_ack(0), 32'h20, "R8 second ack");
        wr(a_eoi(0), 32'h0);
        rd_chk(a_ack(0), 32'hFF, "R6 spurious");
        irq_chk(2'b00, "R6 no state change");

        // level sources and nesting
        set_src(2, 1'b1); idle(3);
        irq_chk(2'b01, "R9 level pending");
        rd_chk(a_ack(0), 32'h22, "R5 ack level");
        irq_chk(2'b00, "R9 in service");
        set_src(1, 1'b1); idle(3);
        irq_chk(2'b11, "R7 higher preempts");
        rd_chk(a_ack(0), 32'h21, "R7 nested ack");
        irq_chk(2'b00, "R7 busy elsewhere");
        wr(a_eoi(0), 32'h0);
        irq_chk(2'b11, "R9 level reoffered");
        set_src(1, 1'b0); idle(3);
        irq_chk(2'b00, "R9 level dropped");
        wr(a_eoi(0), 32'h0);
        irq_chk(2'b01, "R7 lower level retired last");
        rd_chk(a_ack(0), 32'h22, "R9 reack");
        set_src(2, 1'b0); idle(3);
        wr(a_eoi(0), 32'h0);
        irq_chk(2'b00, "R7 all retired");

        // tie on equal priority
        @(negedge clk); src_in[4] = 1'b1; src_in[5] = 1'b1;
        idle(3);
        irq_chk(2'b10, "R5 tie pending");
        rd_chk(a_ack(1), 32'h24, "R5 tie lowest index");
        irq_chk(2'b00, "R7 equal to in-service blocked");
        set_src(4, 1'b0); idle(3);
        wr(a_eoi(1), 32'h0);
        rd_chk(a_ack(1), 32'h25, "R5 next source");
        set_src(5, 1'b0); idle(3);
        wr(a_eoi(1), 32'h0);
        irq_chk(2'b00, "R7 cpu1 clear");

        // mask
        wr(a_vp(4), 32'h80C5_0024);
        rd_chk(a_vp(4), 32'h80C5_0024, "R2 mask readback");
        set_src(4, 1'b1); idle(3);
        irq_chk(2'b00, "R10 masked");
        rd_chk(a_ack(1), 32'hFF, "R10 masked ack");
        set_src(4, 1'b0);

        // programmable spurious
        wr(SPUR, 32'h5A);
        rd_chk(a_ack(1), 32'h5A, "R6 programmed spurious");

        // active-low level source
        wr(a_vp(6), 32'h0046_0026); wr(a_dst(6), 32'h2); idle(3);
        irq_chk(2'b00, "R13 inactive high");
        set_src(6, 1'b0); idle(3);
        irq_chk(2'b10, "R13 active low");
        rd_chk(a_ack(1), 32'h26, "R13 ack");
        set_src(6, 1'b1); idle(3);
        wr(a_eoi(1), 32'h0);
        irq_chk(2'b00, "R13 released");

        // passthrough bit
        wr(GCONF, 32'h2);
        rd_chk(GCONF, 32'h2, "R12 stored bit");

        // soft reset
        set_src(1, 1'b1);
        wr(GCONF, 32'h1);
        rd_chk(GCONF, 32'h1, "R11 busy");
        idle(8);
        rd_chk(GCONF, 32'h0, "R11 self clear");
        rd_chk(SPUR, 32'hFF, "R11 spurious restored");
        rd_chk(a_vp(0), 32'h8000_0000, "R11 vecpri restored");
        rd_chk(a_tp(0), 32'hF, "R11 task restored");
        rd_chk(a_dst(1), 32'h0, "R11 dest restored");
        irq_chk(2'b00, "R11 no delivery");
        set_src(1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule